// File: doc/BRIEF.md
# Floating-Point Operand Classifier

This block inspects one IEEE-754 operand, either single precision (32 bits) or double precision (64 bits), and reports which of ten categories it belongs to as a one-hot mask. The categories keep the sign apart for zeros, subnormals, normals and infinities, and they separate quiet NaNs from signaling NaNs. A floating-point unit uses the block to carry out a class-test operation and writes the mask, zero-extended, into a destination register.

The operand comes in on a 64-bit bus. For single precision only the low 32 bits are examined. The result is registered. The output valid follows the input valid by one clock.

Top module: `fp_class_unit`

## Requirements
- R1: Mask bit meanings (bit index: class) are 9 positive zero, 8 positive subnormal, 7 positive normal, 6 positive infinity, 5 negative zero, 4 negative subnormal, 3 negative normal, 2 negative infinity, 1 quiet NaN, 0 signaling NaN.
- R2: With precision select 0 (single), the sign is bit 31, the exponent is bits 30:23 and the fraction is bits 22:0; bits 63:32 of the operand have no effect.
- R3: With precision select 1 (double), the sign is bit 63, the exponent is bits 62:52 and the fraction is bits 51:0.
- R4: An exponent of all zeros with a zero fraction is a signed zero, and with a nonzero fraction it is a signed subnormal.
- R5: An exponent of all ones with a zero fraction is a signed infinity. Any other exponent value is a signed normal.
- R6: An exponent of all ones with a nonzero fraction is a NaN. It is quiet when the fraction MSB is 1 and signaling when it is 0, whatever the sign.
- R7: Exactly one bit of the 10-bit class field is set for every operand.
- R8: The result is zero-extended: bits 63:10 are always 0. When single precision is selected, the result therefore fits within 32 bits.
- R9: out_valid is high exactly one clock after in_valid. The result register loads only on a valid input and holds otherwise. Synchronous active-high reset clears out_valid and the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand is valid this cycle |
| in_dbl | input | 1 | 1 = double precision, 0 = single precision |
| in_operand | input | 64 | Operand bits; single precision uses bits 31:0 |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_mask | output | 64 | Zero-extended one-hot class mask |

## Verification
The decode is purely combinational from the operand fields into a single register stage. A wrong field boundary or a wrong priority therefore shows up at out_mask on the clock edge after the operand is presented. The visible signs are a different one-hot bit, more than one bit set, or no bit set at all. A register that fails to hold or fails to load shows up as a stale mask on the next valid cycle, or as an out_valid that does not match the delayed in_valid. The sweeps cover every exponent class, both signs, both NaN kinds and garbage in the upper word, for each precision.

// File: rtl/fp_class_pkg.sv
package fp_class_pkg;

    localparam int unsigned OPW     = 64;
    localparam int unsigned CLS_W   = 10;
    localparam int unsigned SP_EXPW = 8;
    localparam int unsigned SP_FRW  = 23;
    localparam int unsigned DP_EXPW = 11;
    localparam int unsigned DP_FRW  = 52;

    // Bit index of each class in the mask (fixed by consumers)
    localparam int unsigned CB_PZERO = 9;
    localparam int unsigned CB_PSUB  = 8;
    localparam int unsigned CB_PNORM = 7;
    localparam int unsigned CB_PINF  = 6;
    localparam int unsigned CB_NZERO = 5;
    localparam int unsigned CB_NSUB  = 4;
    localparam int unsigned CB_NNORM = 3;
    localparam int unsigned CB_NINF  = 2;
    localparam int unsigned CB_QNAN  = 1;
    localparam int unsigned CB_SNAN  = 0;

    typedef enum logic [2:0] {
        K_ZERO, K_SUB, K_NORM, K_INF, K_QNAN, K_SNAN
    } kind_e;

    // Precision-independent view of an operand
    typedef struct packed {
        logic  sign;
        logic  exp_zero;
        logic  exp_ones;
        logic  frac_zero;
        logic  frac_msb;
    } fields_t;

    typedef struct packed {
        kind_e kind;
        logic  sign;
    } class_t;

    function automatic logic [CLS_W-1:0] encode_class(class_t c);
        logic [CLS_W-1:0] m;
        m = '0;
        unique case (c.kind)
            K_ZERO: m[c.sign ? CB_NZERO : CB_PZERO] = 1'b1;
            K_SUB:  m[c.sign ? CB_NSUB  : CB_PSUB ] = 1'b1;
            K_NORM: m[c.sign ? CB_NNORM : CB_PNORM] = 1'b1;
            K_INF:  m[c.sign ? CB_NINF  : CB_PINF ] = 1'b1;
            K_QNAN: m[CB_QNAN] = 1'b1;
            default: m[CB_SNAN] = 1'b1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/fp_field_extract.sv
module fp_field_extract
    import fp_class_pkg::*;
#(
    parameter int unsigned EXPW = 8,
    parameter int unsigned FRW  = 23,
    localparam int unsigned W   = 1 + EXPW + FRW
) (
    input  logic [W-1:0] operand,
    output fields_t      fields
);
    logic [EXPW-1:0] exp_f;
    logic [FRW-1:0]  frac_f;

    always_comb begin
        exp_f            = operand[W-2 -: EXPW];
        frac_f           = operand[FRW-1:0];
        fields.sign      = operand[W-1];
        fields.exp_zero  = (exp_f == '0);
        fields.exp_ones  = (exp_f == '1);
        fields.frac_zero = (frac_f == '0);
        fields.frac_msb  = frac_f[FRW-1];
    end
endmodule

// File: rtl/fp_kind_decode.sv
module fp_kind_decode
    import fp_class_pkg::*;
(
    input  fields_t f,
    output class_t  cls
);
    always_comb begin
        cls.sign = f.sign;
        if (f.exp_ones) begin
            if (f.frac_zero)     cls.kind = K_INF;
            else if (f.frac_msb) cls.kind = K_QNAN;
            else                 cls.kind = K_SNAN;
        end else if (f.exp_zero) begin
            cls.kind = f.frac_zero ? K_ZERO : K_SUB;
        end else begin
            cls.kind = K_NORM;
        end
    end
endmodule

// File: rtl/fp_class_unit.sv
module fp_class_unit
    import fp_class_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic           in_dbl,
    input  logic [OPW-1:0] in_operand,
    output logic           out_valid,
    output logic [OPW-1:0] out_mask
);
    localparam int unsigned SPW = 1 + SP_EXPW + SP_FRW;

    fields_t          sp_f, dp_f, sel_f;
    class_t           cls;
    logic [CLS_W-1:0] mask_d;
    logic [CLS_W-1:0] mask_q;

    fp_field_extract #(.EXPW(SP_EXPW), .FRW(SP_FRW)) u_sp (
        .operand (in_operand[SPW-1:0]),
        .fields  (sp_f)
    );

    fp_field_extract #(.EXPW(DP_EXPW), .FRW(DP_FRW)) u_dp (
        .operand (in_operand),
        .fields  (dp_f)
    );

    assign sel_f = in_dbl ? dp_f : sp_f;

    fp_kind_decode u_dec (
        .f   (sel_f),
        .cls (cls)
    );

    assign mask_d = encode_class(cls);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            mask_q    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) mask_q <= mask_d;
        end
    end

    assign out_mask = {{(OPW-CLS_W){1'b0}}, mask_q};

    // R7: exactly one class bit after any accepted operand
    p_onehot_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> $countones(out_mask) == 1);

    // R9: valid latency of one cycle
    p_latency_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R9: result holds without a valid input
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(mask_q));

    // R6: NaN class never reported together with a sign-carrying class
    p_nan_excl_r6: assert property (@(posedge clk) disable iff (rst)
        (out_mask[CB_QNAN] || out_mask[CB_SNAN]) |-> out_mask[CLS_W-1:2] == '0);

    // R8: upper bits stay zero
    p_zext_r8: assert property (@(posedge clk) disable iff (rst)
        out_mask[OPW-1:CLS_W] == '0);

endmodule

// File: tb/sim_fp_class_unit.sv
module sim_fp_class_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_dbl;
    logic [63:0] in_operand;
    logic        out_valid;
    logic [63:0] out_mask;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    fp_class_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_dbl(in_dbl),
        .in_operand(in_operand), .out_valid(out_valid), .out_mask(out_mask)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Independent arithmetic reference (R1, R4, R5, R6)
    function automatic logic [63:0] ref_mask(logic dbl, logic [63:0] op);
        logic s; int e, emax; logic fz, fm;
        if (dbl) begin
            s = op[63]; e = int'(op[62:52]); emax = 2047;
            fz = (op[51:0] == 0); fm = op[51];
        end else begin
            s = op[31]; e = int'(op[30:23]); emax = 255;
            fz = (op[22:0] == 0); fm = op[22];
        end
        if (e == emax && !fz) return fm ? 64'd2 : 64'd1;
        if (e == emax)        return s ? 64'd4 : 64'd64;
        if (e == 0 && fz)     return s ? 64'd32 : 64'd512;
        if (e == 0)           return s ? 64'd16 : 64'd256;
        return s ? 64'd8 : 64'd128;
    endfunction

    task automatic apply(logic dbl, logic [63:0] op, string req);
        logic [63:0] e;
        e = ref_mask(dbl, op);
        @(negedge clk);
        in_valid = 1'b1; in_dbl = dbl; in_operand = op;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, {63'd0, out_valid}, 64'd1);
        check(req, out_mask, e);
        check("R7", 64'($countones(out_mask[9:0])), 64'd1);
        check("R8", {54'd0, out_mask[63:10]} , 64'd0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [63:0] op;
        rst = 1'b1; in_valid = 1'b0; in_dbl = 1'b0; in_operand = '0;
        repeat (3) @(negedge clk);
        check("R9 reset valid", {63'd0, out_valid}, 64'd0);
        check("R9 reset mask", out_mask, 64'd0);
        rst = 1'b0;

        // Fixed corners, R1 bit map single precision
        apply(0, 64'h0000_0000_0000_0000, "R1 +0");
        apply(0, 64'h0000_0000_8000_0000, "R4 -0");
        apply(0, 64'h0000_0000_0000_0001, "R4 +sub");
        apply(0, 64'h0000_0000_807F_FFFF, "R4 -sub");
        apply(0, 64'h0000_0000_3F80_0000, "R5 +norm");
        apply(0, 64'h0000_0000_FF80_0000, "R5 -inf");
        apply(0, 64'h0000_0000_7FC0_0000, "R6 qnan");
        apply(0, 64'h0000_0000_FFA0_0000, "R6 snan");
        apply(0, 64'hFFFF_FFFF_0000_0000, "R2 upper ignored");
        apply(1, 64'h7FF0_0000_0000_0000, "R3 +inf");
        apply(1, 64'hFFF8_0000_0000_0000, "R6 dbl qnan");
        apply(1, 64'h7FF0_0000_0000_0001, "R6 dbl snan");
        apply(1, 64'h0000_0000_FFFF_FFFF, "R3 +sub");
        apply(1, 64'h8000_0000_0000_0000, "R3 -0");

        // Sweep: every single exponent x sign x fraction pattern, junk upper
        for (int ex = 0; ex < 256; ex++)
            for (int k = 0; k < 8; k++) begin
                op = {32'hDEAD_BEEF, k[2], ex[7:0],
                      k[1], 21'd0, k[0]};
                apply(0, op, "R2 sweep");
            end
        // Sweep: double exponent edges and a stride
        for (int ex = 0; ex < 2048; ex += 15)
            for (int k = 0; k < 8; k++) begin
                op = {k[2], ex[10:0], k[1], 50'd0, k[0]};
                apply(1, op, "R3 sweep");
            end
        for (int k = 0; k < 8; k++) begin
            apply(1, {k[2], 11'h7FF, k[1], 50'd0, k[0]}, "R5 dbl top");
            apply(1, {k[2], 11'h7FE, k[1], 50'd0, k[0]}, "R5 dbl norm");
        end

        // R9: hold without valid
        apply(0, 64'h0000_0000_7F80_0000, "R9 load");
        @(negedge clk);
        in_operand = 64'h0; in_dbl = 1'b0;
        @(negedge clk);
        check("R9 hold valid", {63'd0, out_valid}, 64'd0);
        check("R9 hold mask", out_mask, 64'd64);

        // R9: reset clears
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R9 rst mask", out_mask, 64'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule